// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two parallel data ports, called side A and side B, and lets either one be driven from the other. Each side owns a capture register with a clock of its own: a rising edge on the A capture clock stores the word present at side A, and a rising edge on the B capture clock stores the word present at side B. These captures happen on every edge, whatever the enable and direction inputs are doing. Storage therefore keeps working while both ports are isolated.

When the active-low enable is asserted, the direction input picks which side is driven. The driven side carries one of two things, chosen by a per-direction select:
- the live word at the opposite port, passed straight through, or
- the word held in the opposite side's register.

Each port stands in for a three-state pin with a separate input, output and output-enable. The surrounding pad logic or bus fabric resolves the pin, so the block itself contains no internal three-state nets. The enables are decoded from the control inputs with no clock in the path, so a change of direction or enable takes effect at once.

Top module: `reg_bus_xcvr`

## Requirements
- R1: An active-low asynchronous reset (`rstN` low) clears both capture registers to zero.
- R2: On every rising edge of `capAClk`, the A register loads the word on `aIn`.
- R3: On every rising edge of `capBClk`, the B register loads the word on `bIn`.
- R4: Captures into both registers happen whatever the values of `enN` and `dirAtoB`, including while both ports are isolated.
- R5: With `enN` high, both `aOe` and `bOe` are 0 (isolation).
- R6: With `enN` low, `dirAtoB` = 0 gives `aOe` = 1 and `bOe` = 0, and `dirAtoB` = 1 gives `bOe` = 1 and `aOe` = 0.
- R7: While side A is driven and `useStoredB2A` = 0, `aOut` equals the live `bIn`.
- R8: While side A is driven and `useStoredB2A` = 1, `aOut` equals the B register.
- R9: While side B is driven and `useStoredA2B` = 0, `bOut` equals the live `aIn`.
- R10: While side B is driven and `useStoredA2B` = 1, `bOut` equals the A register.
- R11: `aOe` and `bOe` are never 1 at the same time.
- R12: The word on a driven port's own input has no effect on that port's output.
- R13: A port output whose enable is 0 reads as all zeros.
- R14: Changes on `enN`, `dirAtoB` and the selects reach the enables and outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous reset of both capture registers, active low |
| capAClk | input | 1 | Capture clock for the A register, rising edge |
| capBClk | input | 1 | Capture clock for the B register, rising edge |
| enN | input | 1 | Global output enable, active low |
| dirAtoB | input | 1 | 1: side B is driven; 0: side A is driven |
| useStoredA2B | input | 1 | 1: side B gets the A register; 0: side B gets the live A word |
| useStoredB2A | input | 1 | 1: side A gets the B register; 0: side A gets the live B word |
| aIn | input | WIDTH | Word seen at port A |
| aOut | output | WIDTH | Word driven onto port A |
| aOe | output | 1 | Drive enable for port A |
| bIn | input | WIDTH | Word seen at port B |
| bOut | output | WIDTH | Word driven onto port B |
| bOe | output | 1 | Drive enable for port B |

## Verification
The bench sweeps all sixteen settings of enable, direction and the two selects. Under each setting it stores one word and then presents a different one, so live and stored sources always differ. A swapped or inverted select would show the wrong word, and a register wired to the wrong side would show the other side's value.

A dedicated sequence stores words while both ports are isolated and then reads each one out in its own direction. A design that gated capture with the enable would return zero or an old word.

Further cases cover the following:
- Toggling a driven port's own input, which catches a loop-back of `aOut` from `aIn`.
- Flipping direction with no clock running, which catches enables that were registered.
- Checking both enables under every setting, which catches any overlap of the two drivers.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes passed from the control decoder to the datapath.
  typedef struct packed {
    logic driveA;     // port A is the driven side
    logic driveB;     // port B is the driven side
    logic storedToA;  // side A takes the B register rather than live B
    logic storedToB;  // side B takes the A register rather than live A
  } xcvrStrobes_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         enN,
  input  logic         dirAtoB,
  input  logic         useStoredA2B,
  input  logic         useStoredB2A,
  output xcvrStrobes_t strobes
);

  logic enabled;

  // Purely combinational decode: no clock between controls and enables.
  always_comb begin
    enabled           = ~enN;
    strobes.driveA    = enabled & ~dirAtoB;
    strobes.driveB    = enabled &  dirAtoB;
    strobes.storedToA = useStoredB2A;
    strobes.storedToB = useStoredA2B;
  end

  always_comb begin
    if (!$isunknown({enN, dirAtoB})) begin
      AST_ISOLATE_BOTH: assert (!enN || (!strobes.driveA && !strobes.driveB)); // R5
      AST_DIR_PICKS_SIDE: assert (enN || (strobes.driveB == dirAtoB)); // R6
    end
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rstN,
  input  logic             capAClk,
  input  logic             capBClk,
  input  xcvrStrobes_t     strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);

  localparam logic [WIDTH-1:0] ZERO_WORD = '0;

  logic [WIDTH-1:0] aRegQ;
  logic [WIDTH-1:0] bRegQ;
  logic [WIDTH-1:0] toASel;
  logic [WIDTH-1:0] toBSel;

  // Capture registers: each on its own clock, never gated by the enables.
  always_ff @(posedge capAClk or negedge rstN) begin
    if (!rstN) aRegQ <= ZERO_WORD;
    else       aRegQ <= aIn;
  end

  always_ff @(posedge capBClk or negedge rstN) begin
    if (!rstN) bRegQ <= ZERO_WORD;
    else       bRegQ <= bIn;
  end

  // Per-bit lanes: source mux, then output gating.
  // The A register feeds only side B, and the B register feeds only side A.
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign toASel[i] = strobes.storedToA ? bRegQ[i] : bIn[i];
    assign toBSel[i] = strobes.storedToB ? aRegQ[i] : aIn[i];
    assign aOut[i]   = strobes.driveA & toASel[i];
    assign bOut[i]   = strobes.driveB & toBSel[i];
  end

  assign aOe = strobes.driveA;
  assign bOe = strobes.driveB;

  always_comb begin
    if (!$isunknown(strobes)) begin
      AST_ONE_DRIVER: assert (!(aOe && bOe)); // R11
      AST_QUIET_A: assert (aOe || (aOut == ZERO_WORD)); // R13
      AST_QUIET_B: assert (bOe || (bOut == ZERO_WORD)); // R13
    end
  end

  AST_CAPTURE_A: assert property (@(posedge capAClk) disable iff (!rstN)
    1'b1 |=> (aRegQ == $past(aIn))); // R2
  AST_CAPTURE_B: assert property (@(posedge capBClk) disable iff (!rstN)
    1'b1 |=> (bRegQ == $past(bIn))); // R3

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rstN,
  input  logic             capAClk,
  input  logic             capBClk,
  input  logic             enN,
  input  logic             dirAtoB,
  input  logic             useStoredA2B,
  input  logic             useStoredB2A,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);

  xcvrStrobes_t strobes;

  xcvr_ctrl ctrl_i (
    .enN          (enN),
    .dirAtoB      (dirAtoB),
    .useStoredA2B (useStoredA2B),
    .useStoredB2A (useStoredB2A),
    .strobes      (strobes)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) dp_i (
    .rstN    (rstN),
    .capAClk (capAClk),
    .capBClk (capBClk),
    .strobes (strobes),
    .aIn     (aIn),
    .bIn     (bIn),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bOe     (bOe)
  );

endmodule

// File: tb/reg_bus_xcvr_tb_top.sv
module reg_bus_xcvr_tb_top;

  localparam int W = 8;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz pacing clock

  logic rstN, capAClk, capBClk, enN, dirAtoB, useStoredA2B, useStoredB2A;
  logic [W-1:0] aIn, bIn, aOut, bOut;
  logic aOe, bOe;

  reg_bus_xcvr #(.WIDTH(W)) dut_i (
    .rstN(rstN), .capAClk(capAClk), .capBClk(capBClk), .enN(enN),
    .dirAtoB(dirAtoB), .useStoredA2B(useStoredA2B), .useStoredB2A(useStoredB2A),
    .aIn(aIn), .aOut(aOut), .aOe(aOe), .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [W-1:0] mA, mB;  // bench's own record of what the registers should hold

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulseA();
    #1 capAClk = 1'b1;
    #2 capAClk = 1'b0;
    #1;
    mA = aIn;
  endtask

  task automatic pulseB();
    #1 capBClk = 1'b1;
    #2 capBClk = 1'b0;
    #1;
    mB = bIn;
  endtask

  // Checks all four outputs against values computed from the requirements.
  task automatic checkAll(input string ctx);
    logic eA, eB;
    logic [W-1:0] oA, oB;
    #1;
    eA = !enN && !dirAtoB;
    eB = !enN &&  dirAtoB;
    oA = eA ? (useStoredB2A ? mB : bIn) : '0;
    oB = eB ? (useStoredA2B ? mA : aIn) : '0;
    chk({ctx, enN ? " R5 aOe" : " R6 aOe"}, {7'd0, aOe}, {7'd0, eA});
    chk({ctx, enN ? " R5 bOe" : " R6 bOe"}, {7'd0, bOe}, {7'd0, eB});
    chk({ctx, !eA ? " R13 aOut" : (useStoredB2A ? " R8 aOut" : " R7 aOut")}, aOut, oA);
    chk({ctx, !eB ? " R13 bOut" : (useStoredA2B ? " R10 bOut" : " R9 bOut")}, bOut, oB);
    chk({ctx, " R11 exclusive"}, {7'd0, aOe & bOe}, 8'd0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < MAX_CYCLES; c++) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rstN = 1'b0; capAClk = 1'b0; capBClk = 1'b0;
    enN = 1'b1; dirAtoB = 1'b0; useStoredA2B = 1'b0; useStoredB2A = 1'b0;
    aIn = '0; bIn = '0;
    mA = '0; mB = '0;
    #5;

    // R1: the registers read as zero during reset, through each stored path.
    enN = 1'b0; dirAtoB = 1'b1; useStoredA2B = 1'b1; aIn = 8'h5A; bIn = 8'hC3;
    #1 chk("R1 A register after reset", bOut, 8'h00);
    dirAtoB = 1'b0; useStoredB2A = 1'b1;
    #1 chk("R1 B register after reset", aOut, 8'h00);
    #4 rstN = 1'b1;
    #4 checkAll("post-reset");

    // Sweep: every control setting x several data patterns.
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int k = 0; k < 8; k++) begin
        {enN, dirAtoB, useStoredA2B, useStoredB2A} = cfg[3:0];
        aIn = W'((k * 37 + cfg * 11 + 5) & 8'hFF);
        bIn = W'((k * 53 + cfg * 29 + 9) & 8'hFF);
        if (k[0]) pulseA();  // R2 / R4
        if (k[1]) pulseB();  // R3 / R4
        aIn = ~aIn ^ W'(k);
        bIn = bIn + W'(8'h71);
        checkAll($sformatf("sweep cfg=%0d k=%0d", cfg, k));
      end
    end

    // R4: store while isolated, then read each word out in its own direction.
    enN = 1'b1; aIn = 8'hA5; bIn = 8'h3C;
    pulseA(); pulseB();
    aIn = 8'h11; bIn = 8'h22;
    enN = 1'b0; dirAtoB = 1'b1; useStoredA2B = 1'b1;
    #1 chk("R4 R10 isolated store A read on B", bOut, 8'hA5);
    dirAtoB = 1'b0; useStoredB2A = 1'b1;
    #1 chk("R4 R8 isolated store B read on A", aOut, 8'h3C);

    // R4: capture while side A is driven.
    aIn = 8'h96; pulseA();
    dirAtoB = 1'b1;
    #1 chk("R4 R2 capture A while A driven", bOut, 8'h96);

    // R12: the driven port's own input does not disturb its output.
    dirAtoB = 1'b0; useStoredB2A = 1'b0; bIn = 8'h4E;
    for (int v = 0; v < 4; v++) begin
      aIn = W'(v * 8'h3B);
      #1 chk("R12 aIn ignored on driven A", aOut, 8'h4E);
    end
    dirAtoB = 1'b1; useStoredA2B = 1'b0; aIn = 8'hD2;
    for (int v = 0; v < 4; v++) begin
      bIn = W'(v * 8'h5F + 1);
      #1 chk("R12 bIn ignored on driven B", bOut, 8'hD2);
    end

    // R14: direction and enable changes act with no capture clock edge.
    dirAtoB = 1'b0;
    #1 chk("R14 dir flip aOe", {7'd0, aOe}, 8'd1);
    chk("R14 dir flip bOe", {7'd0, bOe}, 8'd0);
    enN = 1'b1;
    #1 chk("R14 R5 enable drop aOe", {7'd0, aOe}, 8'd0);
    enN = 1'b0; dirAtoB = 1'b1;
    #1 chk("R14 enable+dir bOe", {7'd0, bOe}, 8'd1);
    useStoredA2B = 1'b1;
    #1 chk("R14 R10 select flip", bOut, mA);

    done = 1'b1;
    report();
  end

endmodule